// File: doc/BRIEF.md
# Configuration frame broadcast writer

This block is a write-only bus slave. It builds 128-bit configuration words out of 32-bit bus writes. Each finished word goes out at once to every configuration-frame endpoint that is present. A one-bit window select on the bus chooses between two 4 KB address windows.

In the register window, the target register address of the outgoing packet comes from the bus address. In the frame-data window, every packet carries one fixed register code, which is set by a parameter. Three writes into a staging buffer hold the lower slices of the word. The write to the top slice releases the packet: one packet bus carries the register address and the 128-bit data, and a valid strobe pulses for each endpoint whose presence bit is set. Reads and writes that are not 32 bits wide change nothing and raise a one-cycle error pulse.

Top module: `cbw_top`

## Requirements
- R1: During and after reset `epValid`, `pktAddr`, `pktData` and `busErr` are zero. All staging slices are zero, so a packet whose only write is the top slice carries zero in bits [95:0].
- R2: An accepted write is `busValid`=1, `busWrite`=1 and `busSize`=2 (size codes: 0 byte, 1 halfword, 2 word, 3 reserved). An accepted write with `busAddr[3:2]` equal to 0, 1 or 2 stores `busWdata` in that slice. A later write to the same slice replaces the earlier value.
- R3: An accepted write with `busAddr[3:2]`=3 releases a packet. From the following cycle, `pktData` holds slice 0 in bits [31:0], slice 1 in [63:32], slice 2 in [95:64] and the releasing write data in [127:96].
- R4: With `busWindow`=0, the released `pktAddr` equals `busAddr[9:4]` of the releasing write. `busAddr[11:10]` has no effect.
- R5: With `busWindow`=1, the released `pktAddr` equals the parameter FRAME_CODE, whatever the value of `busAddr[11:4]`.
- R6: In the cycle after a release, `epValid` equals the `presentMask` sampled at the release. In every other cycle `epValid` is zero. `pktAddr` and `pktData` hold their values until the next release.
- R7: A release clears the staging slices. A slice that is not written before the next release reads as zero in that packet.
- R8: A read (`busValid`=1, `busWrite`=0) returns `busRdata`=0, pulses `busErr` in the next cycle and leaves the staging slices unchanged.
- R9: A write with `busSize` other than 2 stores nothing and releases no packet, even when it targets slice 3. It pulses `busErr` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWindow | input | 1 | 0 = register window, 1 = frame-data window |
| busAddr | input | 12 | Byte address within the window |
| busSize | input | 2 | Access size code |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, always zero |
| busErr | output | 1 | One-cycle error pulse |
| presentMask | input | 15 | Endpoint presence bits |
| pktAddr | output | 6 | Packet target register address |
| pktData | output | 128 | Packet data |
| epValid | output | 15 | Per-endpoint packet strobe |

## Verification
The bench builds the block with the default fifteen endpoints and sets FRAME_CODE to 6'h2A. That code cannot be confused with a decoded register address of zero or with a reset value, so a frame-data window that still decodes the bus address shows up in the checks. With the full fifteen-bit mask, masks that select only the lowest or only the highest endpoint, a sparse mask and an empty mask, every strobe lane can be seen both gated and ungated. Back-to-back releases and partly filled packets exercise the clearing of the staging slices.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int WORD_W     = 32;
  localparam int SLICE_CNT  = 4;
  localparam int SEL_W      = $clog2(SLICE_CNT);
  localparam int SEL_LSB    = $clog2(WORD_W / 8);
  localparam int REG_ADDR_W = 6;
  localparam int ADDR_LSB   = SEL_LSB + SEL_W;
  localparam int PKT_W      = WORD_W * SLICE_CNT;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef struct packed {
    logic [SLICE_CNT-2:0]  sliceWr;
    logic                  fire;
    logic [REG_ADDR_W-1:0] tgtAddr;
  } cbw_strobe_t;
endpackage

// File: rtl/cbw_ctrl.sv
module cbw_ctrl
  import cbw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [REG_ADDR_W-1:0] FRAME_CODE = 6'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busWindow,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output cbw_strobe_t       strb,
  output logic              busErr
);
  logic             wrOk;
  logic             errNext;
  logic [SEL_W-1:0] sel;

  assign wrOk    = busValid && busWrite && (busSize == SIZE_WORD);
  assign errNext = busValid && (!busWrite || (busSize != SIZE_WORD));
  assign sel     = busAddr[SEL_LSB +: SEL_W];

  genvar i;
  generate
    for (i = 0; i < SLICE_CNT - 1; i++) begin : g_sel
      assign strb.sliceWr[i] = wrOk && (sel == SEL_W'(i));
    end
  endgenerate

  assign strb.fire    = wrOk && (sel == SEL_W'(SLICE_CNT - 1));
  assign strb.tgtAddr = busWindow ? FRAME_CODE : busAddr[ADDR_LSB +: REG_ADDR_W];

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= errNext;
  end

  // R8
  read_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> busErr);

  // R9
  bad_size_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busSize != SIZE_WORD) |-> (strb.sliceWr == '0 && !strb.fire));
endmodule

// File: rtl/cbw_dpath.sv
module cbw_dpath
  import cbw_pkg::*;
#(
  parameter int NUM_EP = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cbw_strobe_t           strb,
  input  logic [WORD_W-1:0]     busWdata,
  input  logic [NUM_EP-1:0]     presentMask,
  output logic [REG_ADDR_W-1:0] pktAddr,
  output logic [PKT_W-1:0]      pktData,
  output logic [NUM_EP-1:0]     epValid
);
  localparam int TOP_LSB = WORD_W * (SLICE_CNT - 1);

  logic [SLICE_CNT-2:0][WORD_W-1:0] stage;
  logic [PKT_W-1:0]                 nextData;

  genvar i;
  generate
    for (i = 0; i < SLICE_CNT - 1; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN || strb.fire)    stage[i] <= '0;
        else if (strb.sliceWr[i])  stage[i] <= busWdata;
      end
      assign nextData[i*WORD_W +: WORD_W] = stage[i];
    end
  endgenerate
  assign nextData[TOP_LSB +: WORD_W] = busWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktAddr <= '0;
      pktData <= '0;
      epValid <= '0;
    end else begin
      epValid <= strb.fire ? presentMask : '0;
      if (strb.fire) begin
        pktAddr <= strb.tgtAddr;
        pktData <= nextData;
      end
    end
  end

  // R6
  strobe_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> (epValid == $past(presentMask)));

  // R6
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fire |=> (epValid == '0 && $stable(pktData) && $stable(pktAddr)));

  // R7
  stage_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> (stage == '0));

  // R3
  top_slice_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> (pktData[TOP_LSB +: WORD_W] == $past(busWdata)));
endmodule

// File: rtl/cbw_top.sv
module cbw_top
  import cbw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_EP = 15,
  parameter logic [REG_ADDR_W-1:0] FRAME_CODE = 6'h01
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic                  busWindow,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [1:0]            busSize,
  input  logic [WORD_W-1:0]     busWdata,
  output logic [WORD_W-1:0]     busRdata,
  output logic                  busErr,
  input  logic [NUM_EP-1:0]     presentMask,
  output logic [REG_ADDR_W-1:0] pktAddr,
  output logic [PKT_W-1:0]      pktData,
  output logic [NUM_EP-1:0]     epValid
);
  cbw_strobe_t strb;

  assign busRdata = '0;

  cbw_ctrl #(.ADDR_W(ADDR_W), .FRAME_CODE(FRAME_CODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWindow(busWindow), .busAddr(busAddr), .busSize(busSize),
    .strb(strb), .busErr(busErr)
  );

  cbw_dpath #(.NUM_EP(NUM_EP)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .presentMask(presentMask), .pktAddr(pktAddr), .pktData(pktData),
    .epValid(epValid)
  );

  // R5
  frame_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busSize == SIZE_WORD && busWindow &&
     busAddr[SEL_LSB +: SEL_W] == SEL_W'(SLICE_CNT - 1)) |=> (pktAddr == FRAME_CODE));

  // R4
  reg_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busSize == SIZE_WORD && !busWindow &&
     busAddr[SEL_LSB +: SEL_W] == SEL_W'(SLICE_CNT - 1))
    |=> (pktAddr == $past(busAddr[ADDR_LSB +: REG_ADDR_W])));
endmodule

// File: tb/cbw_top_tb_top.sv
`timescale 1ns/1ps
module cbw_top_tb_top;
  localparam logic [5:0] CODE = 6'h2A;

  typedef struct {
    logic [5:0]   a;
    logic [127:0] d;
    logic [14:0]  m;
    string        tag;
  } exp_t;

  logic clk = 0;
  logic rstN = 0;
  logic busValid = 0, busWrite = 0, busWindow = 0;
  logic [11:0] busAddr = '0;
  logic [1:0] busSize = 2'd2;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busErr;
  logic [14:0] presentMask = '0;
  logic [5:0] pktAddr;
  logic [127:0] pktData;
  logic [14:0] epValid;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t expQ[$];
  logic [31:0] model[3];

  always #10 clk = ~clk;

  cbw_top #(.FRAME_CODE(CODE)) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWindow(busWindow), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .presentMask(presentMask), .pktAddr(pktAddr), .pktData(pktData),
    .epValid(epValid)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver: one bus access, one cycle; pushes the expected packet
  task automatic wr(input bit win, input logic [11:0] addr, input logic [31:0] data,
                    input string tag);
    int s;
    exp_t e;
    busValid = 1; busWrite = 1; busSize = 2'd2;
    busWindow = win; busAddr = addr; busWdata = data;
    s = int'(addr[3:2]);
    if (s < 3) model[s] = data;
    else begin
      e.a = win ? CODE : addr[9:4];
      e.d = {data, model[2], model[1], model[0]};
      e.m = presentMask;
      e.tag = tag;
      if (presentMask != 0) expQ.push_back(e);
      model[0] = 0; model[1] = 0; model[2] = 0;
    end
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic pkt(input bit win, input logic [11:0] base, input logic [31:0] w0,
                     input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3,
                     input string tag);
    wr(win, base | 12'h0, w0, tag);
    wr(win, base | 12'h4, w1, tag);
    wr(win, base | 12'h8, w2, tag);
    wr(win, base | 12'hC, w3, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done && epValid != 0) begin
      if (expQ.size() == 0) chk(0, "R6 unexpected strobe", 128'(epValid), 0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        chk(epValid == e.m, {e.tag, " R6 mask"}, 128'(epValid), 128'(e.m));
        chk(pktAddr == e.a, {e.tag, " addr"}, 128'(pktAddr), 128'(e.a));
        chk(pktData == e.d, {e.tag, " data R3"}, pktData, e.d);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model[0] = 0; model[1] = 0; model[2] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(epValid == 0 && pktAddr == 0 && pktData == 0 && busErr == 0, "R1 reset outputs",
        {epValid, pktAddr, busErr}, 0);
    rstN = 1;
    @(negedge clk);
    presentMask = 15'h7FFF;
    // R1: only top slice written, lower slices from reset are zero
    wr(0, 12'h01C, 32'hDEAD_0001, "R1");
    // R2 R3 R4 full packet, register window, upper bits set (ignored)
    pkt(0, 12'hC50, 32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003, "R2 R4");
    // R2 overwrite of slice 1 before release
    presentMask = 15'h0001;
    wr(0, 12'h104, 32'hAAAA_AAAA, "R2");
    wr(0, 12'h104, 32'hBBBB_BBBB, "R2");
    wr(0, 12'h100, 32'hCCCC_CCCC, "R2");
    wr(0, 12'h10C, 32'hDDDD_DDDD, "R2 overwrite");
    // R5 frame-data window ignores address
    presentMask = 15'h4000;
    pkt(1, 12'hFF0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h1234_5678, 32'h9ABC_DEF0, "R5");
    // R7 partial packet after release, back-to-back releases
    presentMask = 15'h5A5A;
    wr(0, 12'h208, 32'h7777_7777, "R7");
    wr(0, 12'h20C, 32'h8888_8888, "R7");
    wr(1, 12'h00C, 32'h9999_9999, "R7 back-to-back");
    // R8 read: zero data, error pulse, no state change
    wr(0, 12'h300, 32'h5555_0000, "R8");
    busValid = 1; busWrite = 0; busAddr = 12'h300;
    #1 chk(busRdata == 0, "R8 rdata", 128'(busRdata), 0);
    @(negedge clk);
    busValid = 0;
    chk(busErr == 1, "R8 err pulse", 128'(busErr), 1);
    @(negedge clk);
    chk(busErr == 0, "R8 err one cycle", 128'(busErr), 0);
    // R9 bad size writes: ignored, error pulse
    busValid = 1; busWrite = 1; busSize = 2'd1; busAddr = 12'h300; busWdata = 32'hBAD0_BAD0;
    @(negedge clk);
    busValid = 0; busSize = 2'd2;
    chk(busErr == 1, "R9 err pulse", 128'(busErr), 1);
    busValid = 1; busWrite = 1; busSize = 2'd0; busAddr = 12'h30C; busWdata = 32'hBAD1_BAD1;
    @(negedge clk);
    busValid = 0; busWrite = 0; busSize = 2'd2;
    chk(epValid == 0, "R9 no release on bad size", 128'(epValid), 0);
    @(negedge clk);
    chk(epValid == 0, "R9 no release later", 128'(epValid), 0);
    wr(0, 12'h30C, 32'h6666_6666, "R8 R9 state kept");
    // R6 empty mask: no strobes, packet bus still updated
    presentMask = 15'h0000;
    pkt(0, 12'h3F0, 32'h1, 32'h2, 32'h3, 32'h4, "R6");
    chk(epValid == 0, "R6 empty mask strobe", 128'(epValid), 0);
    chk(pktAddr == 6'h3F, "R6 empty mask addr", 128'(pktAddr), 128'h3F);
    @(negedge clk);
    chk(epValid == 0, "R6 strobe one cycle", 128'(epValid), 0);
    chk(pktData == {32'h4, 32'h3, 32'h2, 32'h1}, "R6 data held", pktData,
        {32'h4, 32'h3, 32'h2, 32'h1});
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R6 scoreboard drained", 128'(expQ.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule